// File: doc/BRIEF.md
# Strand Run-Control and Inter-Processor Interrupt Dispatcher

This unit owns the run state of a small group of hardware strands, four by default. Each strand is in one of three states: running, suspended or halted. Inter-processor interrupt commands arrive on a command port as a type, a target strand and a vector. The unit decodes each command and turns it into a state change, an interrupt-vector post pulse or a reset-request pulse toward the strand. After power-on, only the boot strand runs. Every other strand waits in the suspended state until a command wakes it.

Each strand also has a status register. A write to it stores the active bit, and clearing that bit puts the writing strand to sleep. A read returns a word that holds the strand's own bits, its index and a 5-bit state code for each member of its aligned group of four. A command and a status write can land on the same strand in the same cycle; the command wins. Commands are taken one per cycle, and the ready output is always high.

Top module: `ipi_run_ctrl`

## Requirements
- R1: After reset, strand 0 is running and all other strands are suspended. On `strand_state`, each strand uses 2 bits at [2i+1:2i], coded 0 = suspended, 1 = running, 2 = halted. After reset, strand 0's stored active bit is 1, the other strands' active bits are 0, and all pulse outputs are low.
- R2: A command of type 0 to an existing strand produces `post_valid` for exactly one cycle, in the cycle after acceptance, carrying that strand and vector. `cmd_ready` is always 1.
- R3: A type 0 post moves a suspended strand to running. It leaves a running strand running and a halted strand halted.
- R4: A type 1 command whose vector equals `POR_VEC` (default 1) pulses `rst_req_valid` with the strand index in the next cycle, and the strand becomes running. With any other vector, `err_pulse` rises in the next cycle and nothing else changes.
- R5: A type 2 command puts the target strand into the halted state.
- R6: A type 3 command puts the target strand into the running state.
- R7: A command of type 0 to 3 whose target is at or above `NUM_STRANDS` has no effect and raises no error.
- R8: A command of type 4 or above pulses `err_pulse` in the next cycle and has no other effect.
- R9: A status write to an existing strand with bit 2 clear stores bit 0 as that strand's active bit. If bit 0 is 0, the strand also becomes suspended.
- R10: A status write with bit 2 set pulses `err_pulse` in the next cycle. It stores nothing and changes no state.
- R11: The status read word for strand r is laid out as follows:
  - bit 0 is r's active bit, and bit 2 always reads 0;
  - bits [10:8] hold r;
  - for each strand x in r's aligned group of four, the code for x sits at bits [35-5k:31-5k], where k = x mod 4;
  - the codes are 0x05 for running, 0x00 for suspended and 0x02 for halted;
  - every other bit is 0, and the word is all zero when r is at or above `NUM_STRANDS`.
- R12: When a type 0 to 3 command and a status write name the same existing strand in the same cycle, the command takes effect and the status write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Always 1; one command per cycle |
| cmd_type | input | TYPE_W (3) | 0 post, 1 reset, 2 halt, 3 resume |
| cmd_target | input | TGT_W (3) | Target strand index |
| cmd_vector | input | VEC_W (6) | Interrupt vector or reset trap type |
| sts_wr_en | input | 1 | Status register write |
| sts_wr_strand | input | TGT_W (3) | Writing strand |
| sts_wr_data | input | 64 | Write data (bit 0 active, bit 2 speculation) |
| sts_rd_strand | input | TGT_W (3) | Reading strand |
| sts_rd_data | output | 64 | Assembled status word (combinational) |
| strand_state | output | 2*NUM_STRANDS (8) | Per-strand run state |
| post_valid | output | 1 | Interrupt post pulse |
| post_strand | output | TGT_W (3) | Post target |
| post_vector | output | VEC_W (6) | Posted vector |
| rst_req_valid | output | 1 | Reset request pulse |
| rst_req_strand | output | TGT_W (3) | Reset target |
| err_pulse | output | 1 | Malformed command or unsupported write |

## Verification
The clocked assertions assume that the inputs are known and held stable across each rising edge. They also assume that every accepted command and status write is seen at exactly one edge, because the handshake has no back-pressure. The bench changes its inputs only on falling edges and holds each stimulus for one full cycle. Its random traffic deliberately includes out-of-range targets, undefined types, wrong reset vectors, speculation-enable writes and collisions on the same strand. This means the corner cases also run under the assertions, not only the common paths.

// File: rtl/ipi_rc_pkg.sv
package ipi_rc_pkg;

   typedef enum logic [1:0] {
      RS_SUSP = 2'd0,
      RS_RUN  = 2'd1,
      RS_HALT = 2'd2
   } run_st_e;

   localparam int CMD_POST   = 0;
   localparam int CMD_RESET  = 1;
   localparam int CMD_HALT   = 2;
   localparam int CMD_RESUME = 3;
   localparam int CMD_LAST   = 3;

   localparam int STS_W      = 64;
   localparam int ACT_BIT    = 0;
   localparam int SPEC_BIT   = 2;
   localparam int ID_LSB     = 8;
   localparam int GROUP      = 4;
   localparam int CODE_W     = 5;
   localparam int FIELD_LSB0 = 31;

   localparam logic [CODE_W-1:0] CODE_RUN  = 5'h05;
   localparam logic [CODE_W-1:0] CODE_IDLE = 5'h00;
   localparam logic [CODE_W-1:0] CODE_HALT = 5'h02;

   function automatic logic [CODE_W-1:0] st_code(run_st_e s);
      case (s)
         RS_RUN:  return CODE_RUN;
         RS_HALT: return CODE_HALT;
         default: return CODE_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
   import ipi_rc_pkg::*;
#(
   parameter int NUM_STRANDS = 4,
   parameter int TGT_W       = 3,
   parameter int TYPE_W      = 3,
   parameter int VEC_W       = 6,
   parameter int POR_VEC     = 1
)(
   input  logic                   cmd_valid,
   input  logic [TYPE_W-1:0]      cmd_type,
   input  logic [TGT_W-1:0]       cmd_target,
   input  logic [VEC_W-1:0]       cmd_vector,
   output logic [NUM_STRANDS-1:0] hit,
   output logic [NUM_STRANDS-1:0] do_post,
   output logic [NUM_STRANDS-1:0] do_reset,
   output logic [NUM_STRANDS-1:0] do_halt,
   output logic [NUM_STRANDS-1:0] do_resume,
   output logic                   cmd_err
);

   logic type_ok, tgt_ok, por_ok;

   always_comb begin
      type_ok = int'(cmd_type) <= CMD_LAST;
      tgt_ok  = int'(cmd_target) < NUM_STRANDS;
      por_ok  = cmd_vector == VEC_W'(POR_VEC);
      cmd_err = cmd_valid && (!type_ok ||
                (tgt_ok && int'(cmd_type) == CMD_RESET && !por_ok));
   end

   for (genvar i = 0; i < NUM_STRANDS; i++) begin : g_sel
      always_comb begin
         hit[i]       = cmd_valid && type_ok && tgt_ok && cmd_target == TGT_W'(i);
         do_post[i]   = hit[i] && int'(cmd_type) == CMD_POST;
         do_reset[i]  = hit[i] && int'(cmd_type) == CMD_RESET && por_ok;
         do_halt[i]   = hit[i] && int'(cmd_type) == CMD_HALT;
         do_resume[i] = hit[i] && int'(cmd_type) == CMD_RESUME;
      end
   end

endmodule

// File: rtl/ipi_strand_fsm.sv
module ipi_strand_fsm
   import ipi_rc_pkg::*;
#(
   parameter bit START_RUN = 1'b0
)(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    ipi_hit,
   input  logic    do_post,
   input  logic    do_reset,
   input  logic    do_halt,
   input  logic    do_resume,
   input  logic    wr_en,
   input  logic    wr_active,
   input  logic    wr_spec,
   output run_st_e state,
   output logic    active
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= START_RUN ? RS_RUN : RS_SUSP;
         active <= START_RUN;
      end else if (ipi_hit) begin
         if (do_reset || do_resume)
            state <= RS_RUN;
         else if (do_halt)
            state <= RS_HALT;
         else if (do_post && state == RS_SUSP)
            state <= RS_RUN;
      end else if (wr_en && !wr_spec) begin
         active <= wr_active;
         if (!wr_active)
            state <= RS_SUSP;
      end
   end

   assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      state != 2'd3);
   assert_post_wakes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (do_post && state == RS_SUSP) |=> state == RS_RUN);
   assert_halt_deaf_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (do_post && state == RS_HALT) |=> state == RS_HALT);
   assert_reset_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      do_reset |=> state == RS_RUN);
   assert_halt_enters_R5: assert property (@(posedge clk) disable iff (!rst_n)
      do_halt |=> state == RS_HALT);
   assert_resume_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      do_resume |=> state == RS_RUN);
   assert_sleep_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_spec && !wr_active && !ipi_hit) |=> (state == RS_SUSP && !active));
   assert_spec_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_spec && !ipi_hit) |=> ($stable(state) && $stable(active)));
   assert_ipi_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ipi_hit && wr_en) |=> $stable(active));

endmodule

// File: rtl/ipi_status_pack.sv
module ipi_status_pack
   import ipi_rc_pkg::*;
#(
   parameter int NUM_STRANDS = 4,
   parameter int TGT_W       = 3
)(
   input  logic [2*NUM_STRANDS-1:0] st_flat,
   input  logic [NUM_STRANDS-1:0]   active,
   input  logic [TGT_W-1:0]         rd_strand,
   output logic [STS_W-1:0]         word
);

   localparam int FIELD_TOP = FIELD_LSB0 + CODE_W - 1;

   always_comb begin
      word = '0;
      if (int'(rd_strand) < NUM_STRANDS) begin
         word[ACT_BIT]            = active[rd_strand];
         word[ID_LSB +: TGT_W]    = rd_strand;
         for (int i = 0; i < NUM_STRANDS; i++) begin
            if ((i / GROUP) == (int'(rd_strand) / GROUP))
               word[FIELD_TOP - CODE_W*(i % GROUP) -: CODE_W] =
                  st_code(run_st_e'(st_flat[2*i +: 2]));
         end
      end
   end

   always_comb begin
      assert_spec_zero_R11: assert (word[SPEC_BIT] == 1'b0);
   end

endmodule

// File: rtl/ipi_run_ctrl.sv
module ipi_run_ctrl
   import ipi_rc_pkg::*;
#(
   parameter int NUM_STRANDS = 4,
   parameter int TGT_W       = 3,
   parameter int TYPE_W      = 3,
   parameter int VEC_W       = 6,
   parameter int POR_VEC     = 1,
   parameter int BOOT_STRAND = 0
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_valid,
   output logic                     cmd_ready,
   input  logic [TYPE_W-1:0]        cmd_type,
   input  logic [TGT_W-1:0]         cmd_target,
   input  logic [VEC_W-1:0]         cmd_vector,
   input  logic                     sts_wr_en,
   input  logic [TGT_W-1:0]         sts_wr_strand,
   input  logic [63:0]              sts_wr_data,
   input  logic [TGT_W-1:0]         sts_rd_strand,
   output logic [63:0]              sts_rd_data,
   output logic [2*NUM_STRANDS-1:0] strand_state,
   output logic                     post_valid,
   output logic [TGT_W-1:0]         post_strand,
   output logic [VEC_W-1:0]         post_vector,
   output logic                     rst_req_valid,
   output logic [TGT_W-1:0]         rst_req_strand,
   output logic                     err_pulse
);

   localparam int MAX_IDX = (1 << TGT_W);

   initial begin
      assert_param_strands: assert (NUM_STRANDS >= 1 && NUM_STRANDS <= MAX_IDX);
      assert_param_idfield: assert (ID_LSB + TGT_W <= FIELD_LSB0 - CODE_W*(GROUP-1));
      assert_param_types:   assert (TYPE_W >= 2);
      assert_param_boot:    assert (BOOT_STRAND >= 0 && BOOT_STRAND < NUM_STRANDS);
      assert_param_vector:  assert (POR_VEC >= 0 && POR_VEC < (1 << VEC_W));
   end

   logic [NUM_STRANDS-1:0] hit, do_post, do_reset, do_halt, do_resume, active;
   logic                   cmd_err, wr_err, wr_tgt_ok;

   assign cmd_ready = 1'b1;

   ipi_cmd_decode #(
      .NUM_STRANDS(NUM_STRANDS), .TGT_W(TGT_W), .TYPE_W(TYPE_W),
      .VEC_W(VEC_W), .POR_VEC(POR_VEC)
   ) u_dec (
      .cmd_valid (cmd_valid),
      .cmd_type  (cmd_type),
      .cmd_target(cmd_target),
      .cmd_vector(cmd_vector),
      .hit       (hit),
      .do_post   (do_post),
      .do_reset  (do_reset),
      .do_halt   (do_halt),
      .do_resume (do_resume),
      .cmd_err   (cmd_err)
   );

   always_comb begin
      wr_tgt_ok = int'(sts_wr_strand) < NUM_STRANDS;
      wr_err    = sts_wr_en && sts_wr_data[SPEC_BIT];
   end

   for (genvar i = 0; i < NUM_STRANDS; i++) begin : g_strand
      run_st_e st_i;
      logic    wr_here;
      assign wr_here = sts_wr_en && wr_tgt_ok && sts_wr_strand == TGT_W'(i);

      if (i == BOOT_STRAND) begin : g_boot
         ipi_strand_fsm #(.START_RUN(1'b1)) u_fsm (
            .clk(clk), .rst_n(rst_n), .ipi_hit(hit[i]), .do_post(do_post[i]),
            .do_reset(do_reset[i]), .do_halt(do_halt[i]), .do_resume(do_resume[i]),
            .wr_en(wr_here), .wr_active(sts_wr_data[ACT_BIT]),
            .wr_spec(sts_wr_data[SPEC_BIT]), .state(st_i), .active(active[i]));
      end else begin : g_idle
         ipi_strand_fsm #(.START_RUN(1'b0)) u_fsm (
            .clk(clk), .rst_n(rst_n), .ipi_hit(hit[i]), .do_post(do_post[i]),
            .do_reset(do_reset[i]), .do_halt(do_halt[i]), .do_resume(do_resume[i]),
            .wr_en(wr_here), .wr_active(sts_wr_data[ACT_BIT]),
            .wr_spec(sts_wr_data[SPEC_BIT]), .state(st_i), .active(active[i]));
      end

      assign strand_state[2*i +: 2] = st_i;
   end

   ipi_status_pack #(.NUM_STRANDS(NUM_STRANDS), .TGT_W(TGT_W)) u_pack (
      .st_flat  (strand_state),
      .active   (active),
      .rd_strand(sts_rd_strand),
      .word     (sts_rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         post_valid     <= 1'b0;
         post_strand    <= '0;
         post_vector    <= '0;
         rst_req_valid  <= 1'b0;
         rst_req_strand <= '0;
         err_pulse      <= 1'b0;
      end else begin
         post_valid     <= |do_post;
         post_strand    <= cmd_target;
         post_vector    <= cmd_vector;
         rst_req_valid  <= |do_reset;
         rst_req_strand <= cmd_target;
         err_pulse      <= cmd_err || wr_err;
      end
   end

   assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready);
   assert_post_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_type == '0 && int'(cmd_target) < NUM_STRANDS)
      |=> (post_valid && post_strand == $past(cmd_target) && post_vector == $past(cmd_vector)));
   assert_one_post_R2: assert property (@(posedge clk) disable iff (!rst_n)
      post_valid |=> !post_valid || $past(cmd_valid));
   assert_bad_por_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && int'(cmd_type) == CMD_RESET && int'(cmd_target) < NUM_STRANDS &&
       cmd_vector != VEC_W'(POR_VEC)) |=> (err_pulse && !rst_req_valid));
   assert_oob_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && int'(cmd_type) <= CMD_LAST && int'(cmd_target) >= NUM_STRANDS &&
       !sts_wr_en) |=> (!post_valid && !rst_req_valid && !err_pulse));
   assert_bad_type_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && int'(cmd_type) > CMD_LAST) |=> (err_pulse && !post_valid && !rst_req_valid));
   assert_spec_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr_en && sts_wr_data[SPEC_BIT]) |=> err_pulse);

endmodule

// File: tb/tb_ipi_run_ctrl.sv
module tb_ipi_run_ctrl;

   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_valid;
   logic        cmd_ready;
   logic [2:0]  cmd_type;
   logic [2:0]  cmd_target;
   logic [5:0]  cmd_vector;
   logic        sts_wr_en;
   logic [2:0]  sts_wr_strand;
   logic [63:0] sts_wr_data;
   logic [2:0]  sts_rd_strand;
   logic [63:0] sts_rd_data;
   logic [7:0]  strand_state;
   logic        post_valid;
   logic [2:0]  post_strand;
   logic [5:0]  post_vector;
   logic        rst_req_valid;
   logic [2:0]  rst_req_strand;
   logic        err_pulse;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   int ref_st [N];
   bit ref_act[N];

   always #10 clk = ~clk;

   ipi_run_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_type(cmd_type), .cmd_target(cmd_target), .cmd_vector(cmd_vector),
      .sts_wr_en(sts_wr_en), .sts_wr_strand(sts_wr_strand), .sts_wr_data(sts_wr_data),
      .sts_rd_strand(sts_rd_strand), .sts_rd_data(sts_rd_data),
      .strand_state(strand_state), .post_valid(post_valid), .post_strand(post_strand),
      .post_vector(post_vector), .rst_req_valid(rst_req_valid),
      .rst_req_strand(rst_req_strand), .err_pulse(err_pulse));

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] code_of(int s);
      return (s == 1) ? 5'h05 : (s == 2) ? 5'h02 : 5'h00;
   endfunction

   function automatic logic [63:0] exp_word(int r);
      logic [63:0] w = '0;
      if (r >= N) return w;
      w[0]    = ref_act[r];
      w[10:8] = 3'(r);
      for (int x = 0; x < N; x++)
         if (x / 4 == r / 4) w[35 - 5*(x % 4) -: 5] = code_of(ref_st[x]);
      return w;
   endfunction

   function automatic logic [7:0] exp_states();
      logic [7:0] v = '0;
      for (int i = 0; i < N; i++) v[2*i +: 2] = 2'(ref_st[i]);
      return v;
   endfunction

   task automatic chk_words(string tag);
      for (int r = 0; r < 6; r++) begin
         sts_rd_strand = 3'(r);
         #1;
         chk(tag, sts_rd_data, exp_word(r));
      end
   endtask

   // one cycle of stimulus; inputs change on the falling edge, results sampled one cycle later
   task automatic step(string tag, bit v, logic [2:0] ty, logic [2:0] tg, logic [5:0] vc,
                       bit wv, logic [2:0] ws, logic [63:0] wd);
      bit e_post = 0, e_rst = 0, e_err = 0, ipi = 0;
      cmd_valid = v; cmd_type = ty; cmd_target = tg; cmd_vector = vc;
      sts_wr_en = wv; sts_wr_strand = ws; sts_wr_data = wd;
      sts_rd_strand = 3'(int'(tg) % N);
      @(posedge clk);
      if (v) begin
         if (ty > 3) e_err = 1;
         else if (int'(tg) < N) begin
            ipi = 1;
            case (ty)
               3'd0: begin e_post = 1; if (ref_st[tg] == 0) ref_st[tg] = 1; end
               3'd1: if (vc == 6'd1) begin e_rst = 1; ref_st[tg] = 1; end else e_err = 1;
               3'd2: ref_st[tg] = 2;
               default: ref_st[tg] = 1;
            endcase
         end
      end
      if (wv) begin
         if (wd[2]) e_err = 1;
         else if (int'(ws) < N && !(ipi && ws == tg)) begin
            ref_act[ws] = wd[0];
            if (!wd[0]) ref_st[ws] = 0;
         end
      end
      @(negedge clk);
      cmd_valid = 0; sts_wr_en = 0;
      chk({tag, " state"}, 64'(strand_state), 64'(exp_states()));
      chk({tag, " post"}, 64'(post_valid), 64'(e_post));
      if (e_post) chk({tag, " post data"}, {post_strand, post_vector}, {tg, vc});
      chk({tag, " rst"}, 64'(rst_req_valid), 64'(e_rst));
      if (e_rst) chk({tag, " rst strand"}, 64'(rst_req_strand), 64'(tg));
      chk({tag, " err"}, 64'(err_pulse), 64'(e_err));
      #1;
      chk({tag, " word"}, sts_rd_data, exp_word(int'(sts_rd_strand)));
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1957));
      rst_n = 0; cmd_valid = 0; cmd_type = 0; cmd_target = 0; cmd_vector = 0;
      sts_wr_en = 0; sts_wr_strand = 0; sts_wr_data = 0; sts_rd_strand = 0;
      for (int i = 0; i < N; i++) begin ref_st[i] = (i == 0); ref_act[i] = (i == 0); end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1: reset state and outputs
      chk("R1 state", 64'(strand_state), 64'h01);
      chk("R1 pulses", {post_valid, rst_req_valid, err_pulse}, 3'b000);
      chk("R2 ready", 64'(cmd_ready), 64'd1);
      chk_words("R1 R11 words");

      step("R3 wake suspended", 1, 3'd0, 3'd1, 6'h2a, 0, 0, 0);
      step("R5 halt",           1, 3'd2, 3'd1, 6'h00, 0, 0, 0);
      step("R3 halted deaf",    1, 3'd0, 3'd1, 6'h11, 0, 0, 0);
      step("R6 resume",         1, 3'd3, 3'd1, 6'h00, 0, 0, 0);
      step("R4 good reset",     1, 3'd1, 3'd2, 6'h01, 0, 0, 0);
      step("R4 bad reset",      1, 3'd1, 3'd3, 6'h05, 0, 0, 0);
      step("R7 out of range",   1, 3'd0, 3'd5, 6'h07, 0, 0, 0);
      step("R8 bad type",       1, 3'd6, 3'd3, 6'h01, 0, 0, 0);
      step("R9 sleep write",    0, 3'd0, 3'd0, 6'h00, 1, 3'd0, 64'h0);
      step("R10 spec write",    0, 3'd0, 3'd2, 6'h00, 1, 3'd2, 64'h4);
      step("R9 active write",   0, 3'd0, 3'd3, 6'h00, 1, 3'd3, 64'h1);
      step("R12 collision",     1, 3'd3, 3'd1, 6'h00, 1, 3'd1, 64'h0);
      step("R2 post running",   1, 3'd0, 3'd1, 6'h3f, 0, 0, 0);
      chk_words("R11 words");

      for (int k = 0; k < 2000; k++) begin
         int r = int'($urandom_range(0, 99));
         logic [2:0] ty = (r < 90) ? 3'($urandom_range(0, 3)) : 3'($urandom_range(4, 7));
         logic [2:0] tg = 3'($urandom_range(0, 5));
         logic [5:0] vc = ($urandom_range(0, 1) == 1) ? 6'd1 : 6'($urandom);
         bit wv = ($urandom_range(0, 3) == 0);
         logic [2:0] ws = ($urandom_range(0, 1) == 1) ? tg : 3'($urandom_range(0, 4));
         logic [63:0] wd = {$urandom, $urandom} & 64'h5;
         if ($urandom_range(0, 7) != 0) wd[2] = 1'b0;
         step("R2 R3 R4 R5 R6 R7 R8 R9 R10 R12 random", $urandom_range(0, 3) != 0,
              ty, tg, vc, wv, ws, wd);
      end
      chk_words("R11 final words");

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule